// File: doc/BRIEF.md
# Layer 3/4 Packet Filter Matcher

This block tests each received Ethernet frame against one programmable filter entry covering IP addresses and TCP/UDP port numbers. The frame arrives as a byte stream, one byte per valid beat, with a start marker on the first byte and an end marker on the last. As the bytes go by, the block picks out the EtherType, the IPv4 or IPv6 source and destination addresses, the transport protocol number and the two port numbers. It compares each of them with the configured value when that field is enabled.

Each address compare ignores a programmable number of low-order bits. Every compare can work in perfect mode, where it passes on equality, or in inverse mode, where it passes on inequality. On the cycle after the last byte, the block reports a one-cycle result that is the AND of all enabled compares. The configuration inputs are static. They are changed only between frames.

Top module: `l34_filter_match`

## Requirements
- R1: `res_valid` pulses high for exactly one cycle, on the cycle after a beat that has `in_valid` and `in_eof` both high. `res_match` is low whenever `res_valid` is low.
- R2: When all four enables (`cfg_src_en`, `cfg_dst_en`, `cfg_sp_en`, `cfg_dp_en`) are low, every frame reports a match, whatever its content. This holds for the all-zero configuration, and the inverse bits then have no effect.
- R3: With `cfg_dp_en` high, the destination port (bytes 2..3 of the L4 header, big-endian) passes when it equals `cfg_dp` and `cfg_dp_inv` is low, or when it differs from `cfg_dp` and `cfg_dp_inv` is high. With `cfg_dp_en` low, the destination port and `cfg_dp_inv` have no effect.
- R4: The source port (bytes 0..1 of the L4 header) follows the same rules as R3, using `cfg_sp_en`, `cfg_sp_inv` and `cfg_sp`.
- R5: When `cfg_l4_udp` is high, port compares pass only for protocol number 17 (UDP). When it is low, they pass only for protocol number 6 (TCP). A frame carrying the other protocol fails every enabled port compare, even in inverse mode.
- R6: For an IPv4 frame, the source address compare ignores the `cfg_src_mask` (0..31) least significant bits, and the destination address compare ignores the `cfg_dst_mask` least significant bits. A count of 31 leaves only the MSb compared. The configured IPv4 addresses are the low 32 bits of `cfg_src_addr` and `cfg_dst_addr`.
- R7: For an IPv6 frame, both address compares ignore C low bits, where C = {`cfg_dst_mask`[1:0], `cfg_src_mask`[4:0]} (0..127). The bits `cfg_dst_mask`[4:2] are unused for IPv6.
- R8: EtherType bytes 12..13 equal to 0x0800 with an IHL (low nibble of byte 14) of at least 5 mark an IPv4 frame. EtherType 0x86DD marks an IPv6 frame. Any other frame fails every enabled address or port compare.
- R9: IPv4 fields sit at fixed offsets: protocol at byte 23, source address at bytes 26..29, destination address at bytes 30..33, and the L4 header at byte 14+4*IHL. IPv6 fields sit at: next header at byte 20, source at bytes 22..37, destination at bytes 38..53, and the L4 header at byte 54.
- R10: An enabled field whose bytes were not all received before the end marker fails its compare.
- R11: With several fields enabled, the frame matches only when every enabled compare passes.
- R12: `cfg_src_inv` and `cfg_dst_inv` turn an enabled address compare into a pass on inequality of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| cfg_src_en | input | 1 | Source address compare enable |
| cfg_src_inv | input | 1 | Source address inverse mode |
| cfg_src_mask | input | 5 | Source ignored low bits; IPv6 count low part |
| cfg_src_addr | input | 128 | Source address (IPv4 in bits 31:0) |
| cfg_dst_en | input | 1 | Destination address compare enable |
| cfg_dst_inv | input | 1 | Destination address inverse mode |
| cfg_dst_mask | input | 5 | Destination ignored low bits; bits 1:0 are the IPv6 count high part |
| cfg_dst_addr | input | 128 | Destination address (IPv4 in bits 31:0) |
| cfg_l4_udp | input | 1 | 1: UDP ports, 0: TCP ports |
| cfg_sp_en | input | 1 | Source port compare enable |
| cfg_sp_inv | input | 1 | Source port inverse mode |
| cfg_sp | input | 16 | Source port value |
| cfg_dp_en | input | 1 | Destination port compare enable |
| cfg_dp_inv | input | 1 | Destination port inverse mode |
| cfg_dp | input | 16 | Destination port value |
| res_valid | output | 1 | Result strobe |
| res_match | output | 1 | Frame matched the filter |

## Verification
The assertions watch, on every cycle, the result timing relative to the end marker and the qualification of the match by the strobe. They also check that an open filter always matches, and that a reported match under an enabled destination-port compare agrees with the captured port in perfect or inverse mode. Only the bench's frames can show correct field extraction at each offset: the IHL-dependent L4 position, the mask counts at their boundaries, the joined IPv6 count, the protocol select, truncation and non-IP EtherTypes. These frames are needed because each of those behaviours depends on which byte landed where.

// File: rtl/l34_filter_match.sv
module l34_filter_match #(
  parameter int IDX_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic         in_eof,
  input  logic [7:0]   in_data,
  input  logic         cfg_src_en,
  input  logic         cfg_src_inv,
  input  logic [4:0]   cfg_src_mask,
  input  logic [127:0] cfg_src_addr,
  input  logic         cfg_dst_en,
  input  logic         cfg_dst_inv,
  input  logic [4:0]   cfg_dst_mask,
  input  logic [127:0] cfg_dst_addr,
  input  logic         cfg_l4_udp,
  input  logic         cfg_sp_en,
  input  logic         cfg_sp_inv,
  input  logic [15:0]  cfg_sp,
  input  logic         cfg_dp_en,
  input  logic         cfg_dp_inv,
  input  logic [15:0]  cfg_dp,
  output logic         res_valid,
  output logic         res_match
);
  localparam logic [IDX_W-1:0] ET_HI  = IDX_W'(12);
  localparam logic [IDX_W-1:0] ET_LO  = IDX_W'(13);
  localparam logic [IDX_W-1:0] V4_VH  = IDX_W'(14);
  localparam logic [IDX_W-1:0] V4_PR  = IDX_W'(23);
  localparam logic [IDX_W-1:0] V4_SA  = IDX_W'(26);
  localparam logic [IDX_W-1:0] V4_SZ  = IDX_W'(29);
  localparam logic [IDX_W-1:0] V4_DA  = IDX_W'(30);
  localparam logic [IDX_W-1:0] V4_DZ  = IDX_W'(33);
  localparam logic [IDX_W-1:0] V6_PR  = IDX_W'(20);
  localparam logic [IDX_W-1:0] V6_SA  = IDX_W'(22);
  localparam logic [IDX_W-1:0] V6_SZ  = IDX_W'(37);
  localparam logic [IDX_W-1:0] V6_DA  = IDX_W'(38);
  localparam logic [IDX_W-1:0] V6_DZ  = IDX_W'(53);
  localparam logic [IDX_W-1:0] V6_L4  = IDX_W'(54);
  localparam logic [IDX_W-1:0] ETH_SZ = IDX_W'(14);
  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;

  logic [IDX_W-1:0] idx_q, cur, l4_off;
  logic [15:0]  etype_q, sp_q, dp_q;
  logic [3:0]   ihl_q;
  logic [7:0]   proto_q;
  logic [127:0] src_q, dst_q;
  logic         src_done, dst_done, sp_done, dp_done, pend_q;

  assign cur = in_sof ? '0 : idx_q;

  logic is4, is6, fam4, fam_ok;
  assign is4    = etype_q == 16'h0800;
  assign is6    = etype_q == 16'h86DD;
  assign fam4   = is4 && (ihl_q >= 4'd5);
  assign fam_ok = fam4 || is6;
  assign l4_off = is6 ? V6_L4 : ETH_SZ + IDX_W'({ihl_q, 2'b00});

  logic src_win, dst_win, pr_hit;
  assign src_win = (is4 && cur >= V4_SA && cur <= V4_SZ) || (is6 && cur >= V6_SA && cur <= V6_SZ);
  assign dst_win = (is4 && cur >= V4_DA && cur <= V4_DZ) || (is6 && cur >= V6_DA && cur <= V6_DZ);
  assign pr_hit  = (is4 && cur == V4_PR) || (is6 && cur == V6_PR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      etype_q  <= '0;
      ihl_q    <= '0;
      proto_q  <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      sp_q     <= '0;
      dp_q     <= '0;
      src_done <= 1'b0;
      dst_done <= 1'b0;
      sp_done  <= 1'b0;
      dp_done  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= in_valid & in_eof;
      if (in_valid) begin
        idx_q <= (cur == '1) ? cur : cur + 1'b1;
        if (in_sof) begin
          etype_q  <= '0;
          ihl_q    <= '0;
          proto_q  <= '0;
          src_done <= 1'b0;
          dst_done <= 1'b0;
          sp_done  <= 1'b0;
          dp_done  <= 1'b0;
        end
        if (cur == ET_HI) etype_q[15:8] <= in_data;
        if (cur == ET_LO) etype_q[7:0]  <= in_data;
        if (is4 && cur == V4_VH) ihl_q <= in_data[3:0];
        if (pr_hit) proto_q <= in_data;
        if (src_win) src_q <= {src_q[119:0], in_data};
        if (dst_win) dst_q <= {dst_q[119:0], in_data};
        if ((is4 && cur == V4_SZ) || (is6 && cur == V6_SZ)) src_done <= 1'b1;
        if ((is4 && cur == V4_DZ) || (is6 && cur == V6_DZ)) dst_done <= 1'b1;
        if (fam_ok) begin
          if (cur == l4_off || cur == l4_off + 1'b1)       sp_q <= {sp_q[7:0], in_data};
          if (cur == l4_off + 2'd2 || cur == l4_off + 2'd3) dp_q <= {dp_q[7:0], in_data};
          if (cur == l4_off + 1'b1) sp_done <= 1'b1;
          if (cur == l4_off + 2'd3) dp_done <= 1'b1;
        end
      end
    end
  end

  logic [6:0]   cnt6;
  logic [127:0] m6;
  logic [31:0]  m4s, m4d;
  assign cnt6 = {cfg_dst_mask[1:0], cfg_src_mask};
  assign m6   = {128{1'b1}} << cnt6;
  assign m4s  = {32{1'b1}} << cfg_src_mask;
  assign m4d  = {32{1'b1}} << cfg_dst_mask;

  logic src_eq, dst_eq, src_ok, dst_ok, l4_ok, sp_ok, dp_ok, match_c;
  assign src_eq = is6 ? ~|((src_q ^ cfg_src_addr) & m6)
                      : ~|((src_q[31:0] ^ cfg_src_addr[31:0]) & m4s);
  assign dst_eq = is6 ? ~|((dst_q ^ cfg_dst_addr) & m6)
                      : ~|((dst_q[31:0] ^ cfg_dst_addr[31:0]) & m4d);
  assign src_ok = fam_ok && src_done && (src_eq ^ cfg_src_inv);
  assign dst_ok = fam_ok && dst_done && (dst_eq ^ cfg_dst_inv);
  assign l4_ok  = fam_ok && (proto_q == (cfg_l4_udp ? PROTO_UDP : PROTO_TCP));
  assign sp_ok  = l4_ok && sp_done && ((sp_q == cfg_sp) ^ cfg_sp_inv);
  assign dp_ok  = l4_ok && dp_done && ((dp_q == cfg_dp) ^ cfg_dp_inv);
  assign match_c = (!cfg_src_en || src_ok) && (!cfg_dst_en || dst_ok) &&
                   (!cfg_sp_en || sp_ok) && (!cfg_dp_en || dp_ok);

  assign res_valid = pend_q;
  assign res_match = pend_q && match_c;
endmodule

module l34_filter_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_eof,
  input logic        res_valid,
  input logic        res_match,
  input logic        any_en,
  input logic        dp_en,
  input logic        dp_inv,
  input logic [15:0] dp_cfg,
  input logic [15:0] dp_seen
);
  // R1
  valid_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));
  // R1
  eof_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> res_valid);
  // R1
  match_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_match);
  // R2
  open_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !any_en) |-> res_match);
  // R3
  dport_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_match && dp_en && !dp_inv) |-> dp_seen == dp_cfg);
  // R3
  dport_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_match && dp_en && dp_inv) |-> dp_seen != dp_cfg);
endmodule

bind l34_filter_match l34_filter_match_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .res_valid(res_valid), .res_match(res_match),
  .any_en(cfg_src_en | cfg_dst_en | cfg_sp_en | cfg_dp_en),
  .dp_en(cfg_dp_en), .dp_inv(cfg_dp_inv), .dp_cfg(cfg_dp), .dp_seen(dp_q)
);

// File: tb/l34_filter_match_tb.sv
`timescale 1ns/1ps
module l34_filter_match_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic cfg_src_en, cfg_src_inv, cfg_dst_en, cfg_dst_inv, cfg_l4_udp;
  logic cfg_sp_en, cfg_sp_inv, cfg_dp_en, cfg_dp_inv;
  logic [4:0] cfg_src_mask, cfg_dst_mask;
  logic [127:0] cfg_src_addr, cfg_dst_addr;
  logic [15:0] cfg_sp, cfg_dp;
  logic res_valid, res_match;

  int n_chk = 0, n_fail = 0, flen = 0;
  logic [7:0] frm [0:127];

  always #2 clk = ~clk;

  l34_filter_match dut_i (.*);

  localparam logic [127:0] A6 = 128'h20010db8_00000000_00000000_00000001;
  localparam logic [46:0] VEC [13] = '{
    {1'b0, 8'd6,  16'h1234, 16'h0050, 5'b01010, 1'b1},
    {1'b0, 8'd6,  16'h1234, 16'h0051, 5'b01010, 1'b0},
    {1'b0, 8'd6,  16'h1234, 16'h0051, 5'b00011, 1'b1},
    {1'b0, 8'd6,  16'h1234, 16'h0050, 5'b00011, 1'b0},
    {1'b0, 8'd17, 16'h1234, 16'h0099, 5'b11000, 1'b1},
    {1'b0, 8'd17, 16'h1234, 16'h0050, 5'b01000, 1'b0},
    {1'b0, 8'd6,  16'h1234, 16'h0050, 5'b01100, 1'b0},
    {1'b0, 8'd6,  16'h4321, 16'h0050, 5'b01100, 1'b1},
    {1'b1, 8'd17, 16'haaaa, 16'h0050, 5'b10010, 1'b1},
    {1'b1, 8'd6,  16'h1234, 16'h0051, 5'b10011, 1'b0},
    {1'b0, 8'd1,  16'h0000, 16'h0000, 5'b00000, 1'b1},
    {1'b0, 8'd1,  16'h1234, 16'h0050, 5'b00100, 1'b1},
    {1'b0, 8'd6,  16'h1234, 16'h0051, 5'b01011, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_clear();
    cfg_src_en = 0; cfg_src_inv = 0; cfg_dst_en = 0; cfg_dst_inv = 0; cfg_l4_udp = 0;
    cfg_sp_en = 0; cfg_sp_inv = 0; cfg_dp_en = 0; cfg_dp_inv = 0;
    cfg_src_mask = 0; cfg_dst_mask = 0; cfg_src_addr = 0; cfg_dst_addr = 0;
    cfg_sp = 16'h1234; cfg_dp = 16'h0050;
  endtask

  task automatic build(input bit v6, input logic [3:0] ihl, input logic [7:0] proto,
                       input logic [127:0] src, input logic [127:0] dst,
                       input logic [15:0] sp, input logic [15:0] dp);
    int l4;
    for (int i = 0; i < 128; i++) frm[i] = 8'(i * 7 + 3);
    if (v6) begin
      frm[12] = 8'h86; frm[13] = 8'hDD; frm[14] = 8'h60; frm[20] = proto;
      for (int k = 0; k < 16; k++) begin
        frm[22 + k] = src[127 - 8 * k -: 8];
        frm[38 + k] = dst[127 - 8 * k -: 8];
      end
      l4 = 54;
    end else begin
      frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = {4'h4, ihl}; frm[23] = proto;
      for (int k = 0; k < 4; k++) begin
        frm[26 + k] = src[31 - 8 * k -: 8];
        frm[30 + k] = dst[31 - 8 * k -: 8];
      end
      l4 = 14 + 4 * int'(ihl);
    end
    frm[l4] = sp[15:8]; frm[l4 + 1] = sp[7:0];
    frm[l4 + 2] = dp[15:8]; frm[l4 + 3] = dp[7:0];
    flen = l4 + 12;
  endtask

  task automatic send(input int n, input bit exp, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = frm[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(res_valid === 1'b1, {tag, " strobe"}, 32'(res_valid), 1);
    chk(res_match === exp, tag, 32'(res_match), 32'(exp));
    @(negedge clk);
    chk(res_valid === 1'b0 && res_match === 1'b0, "R1 one-cycle pulse", 32'({res_valid, res_match}), 0);
  endtask

  task automatic run4(input logic [31:0] src, input logic [31:0] dst, input bit exp, input string tag);
    build(1'b0, 4'd5, 8'd6, 128'(src), 128'(dst), 16'h1234, 16'h0050);
    send(flen, exp, tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    cfg_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid === 1'b0 && res_match === 1'b0, "R1 reset state", 32'({res_valid, res_match}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid === 1'b0, "R1 idle after reset", 32'(res_valid), 0);

    // R3 R4 R5 R11 R2 table
    foreach (VEC[i]) begin
      logic [46:0] e;
      e = VEC[i];
      cfg_clear();
      {cfg_l4_udp, cfg_sp_en, cfg_sp_inv, cfg_dp_en, cfg_dp_inv} = e[5:1];
      build(e[46], 4'd5, e[45:38], 128'hC0A80164, 128'h0A000001, e[37:22], e[21:6]);
      send(flen, e[0], $sformatf("R3/R4/R5 vector %0d", i));
    end

    // R6 IPv4 destination masks
    cfg_clear(); cfg_dst_en = 1; cfg_dst_addr = 128'h0A000001;
    run4(32'hC0A80164, 32'h0A000001, 1, "R6 exact");
    run4(32'hC0A80164, 32'h0A000002, 0, "R6 exact miss");
    cfg_dst_mask = 5'd8;
    run4(32'hC0A80164, 32'h0A0000FF, 1, "R6 mask8 in");
    run4(32'hC0A80164, 32'h0A0001FF, 0, "R6 mask8 out");
    cfg_dst_mask = 5'd31;
    run4(32'hC0A80164, 32'h7FFFFFFF, 1, "R6 mask31 msb same");
    run4(32'hC0A80164, 32'h8A000001, 0, "R6 mask31 msb differs");
    // R12
    cfg_dst_mask = 5'd0; cfg_dst_inv = 1;
    run4(32'hC0A80164, 32'h0A000002, 1, "R12 inverse differ");
    run4(32'hC0A80164, 32'h0A000001, 0, "R12 inverse equal");
    // R6 source uses its own count
    cfg_clear(); cfg_src_en = 1; cfg_src_addr = 128'hC0A80164; cfg_src_mask = 5'd4;
    run4(32'hC0A8016F, 32'h0A000001, 1, "R6 src mask4 in");
    run4(32'hC0A80174, 32'h0A000001, 0, "R6 src mask4 out");
    // R11
    cfg_dp_en = 1; cfg_dp = 16'h0051;
    run4(32'hC0A80164, 32'h0A000001, 0, "R11 src ok port bad");

    // R7 IPv6 joined count
    cfg_clear(); cfg_src_en = 1; cfg_src_addr = A6; cfg_dst_mask = 5'b11110;
    build(1'b1, 4'd0, 8'd6, A6 ^ (128'd1 << 63), A6, 16'h1234, 16'h0050);
    send(flen, 1, "R7 count64 in");
    build(1'b1, 4'd0, 8'd6, A6 ^ (128'd1 << 64), A6, 16'h1234, 16'h0050);
    send(flen, 0, "R7 count64 out");
    cfg_dst_mask = 5'd0; cfg_src_mask = 5'd1;
    build(1'b1, 4'd0, 8'd6, A6 ^ 128'd1, A6, 16'h1234, 16'h0050);
    send(flen, 1, "R7 count1 in");
    build(1'b1, 4'd0, 8'd6, A6 ^ 128'd2, A6, 16'h1234, 16'h0050);
    send(flen, 0, "R7 count1 out");
    cfg_clear(); cfg_dst_en = 1; cfg_dst_addr = A6; cfg_dst_mask = 5'd1;
    build(1'b1, 4'd0, 8'd6, A6, A6 ^ (128'd1 << 31), 16'h1234, 16'h0050);
    send(flen, 1, "R7 dst count32 in");
    build(1'b1, 4'd0, 8'd6, A6, A6 ^ (128'd1 << 32), 16'h1234, 16'h0050);
    send(flen, 0, "R7 dst count32 out");

    // R9 options shift the L4 header
    cfg_clear(); cfg_sp_en = 1;
    build(1'b0, 4'd6, 8'd6, 128'hC0A80164, 128'h0A000001, 16'h1234, 16'h0050);
    send(flen, 1, "R9 ihl6 port found");
    build(1'b0, 4'd6, 8'd6, 128'hC0A80164, 128'h0A000001, 16'h1235, 16'h0050);
    send(flen, 0, "R9 ihl6 port differs");

    // R10 truncation
    cfg_clear(); cfg_dp_en = 1;
    build(1'b0, 4'd5, 8'd6, 128'hC0A80164, 128'h0A000001, 16'h1234, 16'h0050);
    send(37, 0, "R10 truncated port");
    send(38, 1, "R10 port just complete");

    // R8 classification
    cfg_clear(); cfg_dst_en = 1; cfg_dst_inv = 1; cfg_dst_addr = 128'h0A000001;
    build(1'b0, 4'd5, 8'd6, 128'hC0A80164, 128'h0A000002, 16'h1234, 16'h0050);
    frm[12] = 8'h08; frm[13] = 8'h06;
    send(flen, 0, "R8 non-IP fails inverse");
    cfg_clear();
    send(flen, 1, "R2 non-IP open filter");
    cfg_sp_en = 1;
    build(1'b0, 4'd4, 8'd6, 128'hC0A80164, 128'h0A000001, 16'h1234, 16'h0050);
    send(flen, 0, "R8 ihl4 rejected");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule